// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block drives the command pins of an SDRAM device from the moment reset is released until the device is ready for normal traffic. It first holds clock enable high and issues only no-operation commands for a programmable settling interval. It then issues a precharge of every bank and a programmable number of auto refresh commands. After that it writes the standard mode register and then the extended mode register. The extended register carries the self-refresh array size and the output drive strength.

Every command occupies one clock cycle. No-operation commands fill the gaps between commands. The length of each gap comes from parameters that give the precharge time, the refresh cycle time and the mode-register delay in clock cycles. A done flag tells the memory controller that it may take over the pins. The flag stays high until the next reset.

The standard mode word, the array-size code and the drive-strength code are inputs. They must be stable from reset release until the done flag rises.

Top module: `sdram_init_seq`

## Requirements
- R1: While rst_ni is low, the outputs show a NOP (cs_no low; ras_no, cas_no and we_no high), cke_o high, addr_o and ba_o zero, and done_o low.
- R2: After reset is released, the block issues exactly WAIT_CYCLES NOP cycles before the first other command. The first of these is the cycle in which reset is released.
- R3: The first command after the wait is precharge-all: cs_no, ras_no and we_no low, cas_no high, addr_o bit 10 high, all other address bits zero and ba_o zero. NOPs follow for T_RP-1 cycles.
- R4: REFRESH_COUNT auto refresh commands follow (cs_no, ras_no and cas_no low, we_no high, addr_o and ba_o zero). Each refresh starts a slot of T_RC cycles, and the slot's remaining cycles are NOPs.
- R5: Right after the last refresh slot comes the standard mode register write: all four strobes low, ba_o = 00, and addr_o equal to mode_word_i.
- R6: T_MRD cycles after the standard write comes the extended mode register write: all four strobes low, ba_o = 10, addr_o[2:0] = pasr_i (000 full, 001 half, 010 quarter array), addr_o[6:5] = drive_i (00 full, 01 half strength), and every other address bit zero.
- R7: Every cycle between commands is a NOP. At least T_MRD cycles separate each mode register write from the next command.
- R8: done_o rises T_MRD cycles after the extended write. It then stays high with NOP outputs until reset.
- R9: cke_o is high in every cycle.
- R10: A reset asserted partway through the sequence returns the outputs to the R1 state at once. Releasing it restarts the whole sequence from the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_word_i | input | ADDR_W | Operand for the standard mode register |
| pasr_i | input | 3 | Self-refresh array size code for the extended register |
| drive_i | input | 2 | Drive strength code for the extended register |
| cke_o | output | 1 | Clock enable |
| cs_no | output | 1 | Chip select, active low |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Address bus |
| done_o | output | 1 | Initialization complete, sticky until reset |

## Verification
The assertions assume that T_MRD is at least 2, so that a mode register write is always followed by a NOP. They also assume that mode_word_i, pasr_i and drive_i do not change while the sequence runs. The extended-register field checks rely on the last point. The stimulus sets these inputs only while reset is held, and uses small timing parameters. It runs the sequence twice with different words. Between the two runs it interrupts a partial run with a reset in the middle of the refresh phase.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;
  typedef enum logic [2:0] {
    ST_WAIT, ST_PRE, ST_RFSH, ST_MRS, ST_EMRS, ST_DONE
  } state_e;

  typedef enum logic [2:0] {
    CMD_NOP, CMD_PRE, CMD_REF, CMD_MRS, CMD_EMRS
  } cmd_e;

  localparam logic [1:0] BA_STD = 2'b00;
  localparam logic [1:0] BA_EXT = 2'b10;
  localparam int         AP_BIT = 10;
endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int          CNT_W   = 8,
  parameter logic [CNT_W-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= RST_VAL;
    else if (load_i)      cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sdram_init_cmd_enc.sv
module sdram_init_cmd_enc
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input  cmd_e              cmd_i,
  input  logic [ADDR_W-1:0] mode_word_i,
  input  logic [2:0]        pasr_i,
  input  logic [1:0]        drive_i,
  output logic              cs_no,
  output logic              ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] ext_word;

  always_comb begin
    ext_word      = '0;
    ext_word[2:0] = pasr_i;
    ext_word[6:5] = drive_i;
  end

  always_comb begin
    {cs_no, ras_no, cas_no, we_no} = 4'b0111;
    ba_o   = '0;
    addr_o = '0;
    unique case (cmd_i)
      CMD_PRE: begin
        {cs_no, ras_no, cas_no, we_no} = 4'b0010;
        addr_o[AP_BIT] = 1'b1;
      end
      CMD_REF:  {cs_no, ras_no, cas_no, we_no} = 4'b0001;
      CMD_MRS: begin
        {cs_no, ras_no, cas_no, we_no} = 4'b0000;
        ba_o   = BA_W'(BA_STD);
        addr_o = mode_word_i;
      end
      CMD_EMRS: begin
        {cs_no, ras_no, cas_no, we_no} = 4'b0000;
        ba_o   = BA_W'(BA_EXT);
        addr_o = ext_word;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W        = 13,
  parameter int BA_W          = 2,
  parameter int WAIT_CYCLES   = 40000,
  parameter int REFRESH_COUNT = 2,
  parameter int T_RP          = 3,
  parameter int T_RC          = 9,
  parameter int T_MRD         = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] mode_word_i,
  input  logic [2:0]        pasr_i,
  input  logic [1:0]        drive_i,
  output logic              cke_o,
  output logic              cs_no,
  output logic              ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);
  localparam int MAX_A  = (WAIT_CYCLES > T_RC) ? WAIT_CYCLES : T_RC;
  localparam int MAX_B  = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int MAX_D  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W  = $clog2(MAX_D + 1);
  localparam int REF_W  = $clog2(REFRESH_COUNT + 1);

  localparam logic [CNT_W-1:0] WAIT_M1 = CNT_W'(WAIT_CYCLES - 1);
  localparam logic [CNT_W-1:0] RP_M1   = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] RC_M1   = CNT_W'(T_RC - 1);
  localparam logic [CNT_W-1:0] MRD_M1  = CNT_W'(T_MRD - 1);
  localparam logic [REF_W-1:0] REF_LAST = REF_W'(REFRESH_COUNT - 1);

  state_e           state_q, state_d;
  logic             load, zero, ref_inc, ref_clr;
  logic [CNT_W-1:0] load_val, cnt;
  logic [REF_W-1:0] ref_q;
  cmd_e             cmd;

  sdram_init_timer #(
    .CNT_W  (CNT_W),
    .RST_VAL(WAIT_M1)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(load_val),
    .cnt_o     (cnt),
    .zero_o    (zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT;
      ref_q   <= '0;
    end else begin
      state_q <= state_d;
      if (ref_clr)      ref_q <= '0;
      else if (ref_inc) ref_q <= ref_q + 1'b1;
    end
  end

  // Each state runs until the timer reaches zero, then loads the next slot.
  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    ref_inc  = 1'b0;
    ref_clr  = 1'b0;
    if (zero) begin
      unique case (state_q)
        ST_WAIT: begin
          state_d = ST_PRE;  load = 1'b1; load_val = RP_M1;
        end
        ST_PRE: begin
          state_d = ST_RFSH; load = 1'b1; load_val = RC_M1; ref_clr = 1'b1;
        end
        ST_RFSH: begin
          load = 1'b1;
          if (ref_q == REF_LAST) begin
            state_d = ST_MRS; load_val = MRD_M1;
          end else begin
            load_val = RC_M1; ref_inc = 1'b1;
          end
        end
        ST_MRS: begin
          state_d = ST_EMRS; load = 1'b1; load_val = MRD_M1;
        end
        ST_EMRS: state_d = ST_DONE;
        default: ;
      endcase
    end
  end

  // The command is issued in the first cycle of each slot.
  always_comb begin
    cmd = CMD_NOP;
    unique case (state_q)
      ST_PRE:  if (cnt == RP_M1)  cmd = CMD_PRE;
      ST_RFSH: if (cnt == RC_M1)  cmd = CMD_REF;
      ST_MRS:  if (cnt == MRD_M1) cmd = CMD_MRS;
      ST_EMRS: if (cnt == MRD_M1) cmd = CMD_EMRS;
      default: ;
    endcase
  end

  sdram_init_cmd_enc #(
    .ADDR_W(ADDR_W),
    .BA_W  (BA_W)
  ) u_enc (
    .cmd_i      (cmd),
    .mode_word_i(mode_word_i),
    .pasr_i     (pasr_i),
    .drive_i    (drive_i),
    .cs_no      (cs_no),
    .ras_no     (ras_no),
    .cas_no     (cas_no),
    .we_no      (we_no),
    .ba_o       (ba_o),
    .addr_o     (addr_o)
  );

  assign cke_o  = 1'b1;
  assign done_o = (state_q == ST_DONE);
endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
  parameter int ADDR_W        = 13,
  parameter int BA_W          = 2,
  parameter int REFRESH_COUNT = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cke_o,
  input logic              cs_no,
  input logic              ras_no,
  input logic              cas_no,
  input logic              we_no,
  input logic [BA_W-1:0]   ba_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              done_o
);
  logic is_nop, is_mrs, is_ref, is_pre, is_std, is_ext;
  logic [7:0] ref_seen;
  logic       std_seen;

  assign is_nop = !cs_no && ras_no && cas_no && we_no;
  assign is_mrs = !cs_no && !ras_no && !cas_no && !we_no;
  assign is_ref = !cs_no && !ras_no && !cas_no && we_no;
  assign is_pre = !cs_no && !ras_no && cas_no && !we_no;
  assign is_std = is_mrs && (ba_o[1:0] == 2'b00);
  assign is_ext = is_mrs && (ba_o[1:0] == 2'b10);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_seen <= '0;
      std_seen <= 1'b0;
    end else begin
      if (is_ref && ref_seen != 8'hff) ref_seen <= ref_seen + 1'b1;
      if (is_std) std_seen <= 1'b1;
    end
  end

  a_r9_cke_high: assert property (@(posedge clk_i) disable iff (!rst_ni) cke_o);
  a_r3_pre_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_pre |-> addr_o[10]);
  a_r5_std_after_refresh: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_std |-> (ref_seen >= 8'(REFRESH_COUNT)));
  a_r6_ext_after_std: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ext |-> std_seen);
  a_r6_ext_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ext |-> (addr_o[4:3] == 2'b00 && addr_o[ADDR_W-1:7] == '0));
  a_r7_mrs_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_mrs |=> is_nop);
  a_r8_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
  a_r8_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (is_nop && std_seen));
endmodule

bind sdram_init_seq sdram_init_chk #(
  .ADDR_W       (ADDR_W),
  .BA_W         (BA_W),
  .REFRESH_COUNT(REFRESH_COUNT)
) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .cke_o (cke_o),
  .cs_no (cs_no),
  .ras_no(ras_no),
  .cas_no(cas_no),
  .we_no (we_no),
  .ba_o  (ba_o),
  .addr_o(addr_o),
  .done_o(done_o)
);

// File: tb/sdram_init_seq_tb.sv
`timescale 1ns/1ps
module sdram_init_seq_tb;
  localparam int AW   = 13;
  localparam int BW   = 2;
  localparam int WAIT = 16;
  localparam int REFS = 3;
  localparam int TRP  = 3;
  localparam int TRC  = 4;
  localparam int TMRD = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [AW-1:0] mode_word = '0;
  logic [2:0] pasr = '0;
  logic [1:0] drive = '0;
  logic cke, cs_n, ras_n, cas_n, we_n, done;
  logic [BW-1:0] ba;
  logic [AW-1:0] addr;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  int    q_cmd[$];
  bit    q_done[$];
  string q_tag[$];

  always #2.5 clk = ~clk;

  sdram_init_seq #(
    .ADDR_W(AW), .BA_W(BW), .WAIT_CYCLES(WAIT), .REFRESH_COUNT(REFS),
    .T_RP(TRP), .T_RC(TRC), .T_MRD(TMRD)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_word_i(mode_word),
    .pasr_i(pasr), .drive_i(drive), .cke_o(cke), .cs_no(cs_n),
    .ras_no(ras_n), .cas_no(cas_n), .we_no(we_n), .ba_o(ba),
    .addr_o(addr), .done_o(done)
  );

  // 0 nop, 1 precharge-all, 2 refresh, 3 standard write, 4 extended write
  function automatic void push(int c, bit d, string t, int n);
    for (int i = 0; i < n; i++) begin
      q_cmd.push_back(c); q_done.push_back(d); q_tag.push_back(t);
    end
  endfunction

  function automatic void build();
    q_cmd.delete(); q_done.delete(); q_tag.delete();
    push(0, 0, "R2", WAIT);
    push(1, 0, "R3", 1); push(0, 0, "R7", TRP - 1);
    for (int r = 0; r < REFS; r++) begin
      push(2, 0, "R4", 1); push(0, 0, "R7", TRC - 1);
    end
    push(3, 0, "R5", 1); push(0, 0, "R7", TMRD - 1);
    push(4, 0, "R6", 1); push(0, 0, "R7", TMRD - 1);
    push(0, 1, "R8", 6);
  endfunction

  task automatic compare(int c, bit d, string t);
    logic [3:0] e_pins;
    logic [AW-1:0] e_addr;
    logic [BW-1:0] e_ba;
    e_pins = 4'b0111; e_addr = '0; e_ba = '0;
    case (c)
      1: begin e_pins = 4'b0010; e_addr[10] = 1'b1; end
      2: e_pins = 4'b0001;
      3: begin e_pins = 4'b0000; e_addr = mode_word; end
      4: begin e_pins = 4'b0000; e_ba = 2'b10;
               e_addr = AW'(pasr) | (AW'(drive) << 5); end
      default: ;
    endcase
    checks++;
    if ({cs_n, ras_n, cas_n, we_n} !== e_pins || addr !== e_addr ||
        ba !== e_ba || done !== d || cke !== 1'b1) begin
      errors++;
      $display("FAIL %s (R9 cke): pins=%b addr=%h ba=%b done=%b cke=%b exp pins=%b addr=%h ba=%b done=%b cke=1",
               t, {cs_n, ras_n, cas_n, we_n}, addr, ba, done, cke,
               e_pins, e_addr, e_ba, d);
    end
  endtask

  // Release reset at a negedge; entry 0 is the cycle of release.
  task automatic run_seq(int limit);
    build();
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    for (int i = 0; i < q_cmd.size() && i < limit; i++) begin
      if (i > 0) @(negedge clk);
      compare(q_cmd[i], q_done[i], q_tag[i]);
    end
  endtask

  task automatic check_reset(string t);
    compare(0, 0, t);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not end, exp completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    mode_word = 13'h0032; pasr = 3'b001; drive = 2'b01;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_reset("R1");
    run_seq(1000);

    // R10: reset in the middle of the refresh phase, then full restart
    @(negedge clk);
    rst_ni = 1'b0;
    mode_word = 13'h0233; pasr = 3'b010; drive = 2'b00;
    #1 check_reset("R1");
    @(negedge clk);
    run_seq(WAIT + TRP + TRC + 2);
    @(negedge clk);
    rst_ni = 1'b0;
    #1 check_reset("R10");
    repeat (2) @(negedge clk);
    check_reset("R10");
    mode_word = 13'h1fff; pasr = 3'b000; drive = 2'b01;
    run_seq(1000);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule